// File: doc/BRIEF.md
# PS/2 Device Frame Transmitter

This block is the sending half of a PS/2 device port. It generates the serial clock itself and moves one byte at a time to the host. Both bus lines are open-drain. For each line the block has an output that pulls the line low and an input that returns the sampled line level. Bytes come in through a valid/ready handshake into a small holding FIFO. The block starts a frame only when it finds the bus idle.

During a frame the block alternates two phases of equal length. In the released phase it leaves CLK high and presents the next bit on DATA. In the driven phase it pulls CLK low, and the host reads the bit then. At the end of every released phase the block checks CLK. If CLK reads low at that point, the host is inhibiting the bus. The block then releases both lines at once and keeps the interrupted byte. It sends that byte again once the host has let go of the bus and the receive-interrupt flag input is low. A clear input empties the FIFO and also drops a byte that is waiting to be resent.

Top module: `ps2_dev_tx`

## Requirements
- R1: A frame starts only while the synchronized CLK and DATA inputs are both high, `rx_int` is low and a byte is available. Until then both pull outputs stay low.
- R2: A frame carries 11 bits, read in the order the host samples them: a 0, then the 8 data bits with bit 0 first, then the parity bit, then a 1.
- R3: The parity bit is 1 exactly when the data byte holds an even number of ones, so the data bits plus parity always hold an odd number of ones.
- R4: Each bit is held with CLK released for HALF_CYC cycles, then CLK is pulled low for HALF_CYC cycles, where HALF_CYC = CLK_HZ/(2*BIT_HZ). DATA does not change while CLK is pulled low.
- R5: If the synchronized CLK input is low at the end of any released phase, including the one that holds the stop bit, both pull outputs go low on the next cycle and the frame is abandoned.
- R6: An abandoned byte is sent again, unchanged, as the next frame. This happens only after the bus is idle again and `rx_int` is low, and it goes ahead of any bytes already queued.
- R7: While `rx_int` is high, no frame starts, whether for a new byte or a resend.
- R8: `tx_done` is high for exactly one cycle, in the cycle where CLK is released after the eleventh low phase. It does not rise for an abandoned frame.
- R9: The FIFO holds up to DEPTH bytes and sends them in arrival order. `tx_ready` is low while it is full.
- R10: `fifo_clr` empties the FIFO and cancels a pending resend. It wins over a push in the same cycle. A frame already in progress still completes.
- R11: After reset both pull outputs are low, `tx_done` is low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte offered for sending |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | FIFO can accept a byte |
| fifo_clr | input | 1 | Empties the FIFO and cancels a pending resend |
| rx_int | input | 1 | Receive-interrupt flag; high blocks every frame start |
| ps2_clk_i | input | 1 | Sampled level of the CLK line |
| ps2_dat_i | input | 1 | Sampled level of the DATA line |
| ps2_clk_pull | output | 1 | Pull the CLK line low |
| ps2_dat_pull | output | 1 | Pull the DATA line low |
| tx_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The assertions watch every cycle for the following:
- DATA stays unchanged while CLK is pulled low.
- Both lines are released in the cycle after an inhibit is seen.
- `tx_done` is never high for two cycles in a row.
- A start happens only from an idle bus with `rx_int` low.
- A resend reuses the same byte.
- The FIFO neither overflows nor keeps entries after a clear.

Other behaviour shows up only in the bench's scenarios, where a host model samples the line:
- the bit order and the parity values;
- the exact phase lengths;
- that a held-off request-to-send delays the start;
- that the retried byte goes ahead of bytes queued behind it;
- that a clear in mid-frame drops only the queued bytes.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int FRAME_BITS = 11;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } tx_state_e;

    typedef enum logic {
        PH_REL,
        PH_LOW
    } tx_phase_e;

    // bit 0 leaves first
    typedef struct packed {
        logic       stop;
        logic       parity;
        logic [7:0] data;
        logic       start;
    } ps2_frame_t;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~^b;
    endfunction

    function automatic ps2_frame_t build_frame(input logic [7:0] b);
        ps2_frame_t f;
        f.start  = 1'b0;
        f.data   = b;
        f.parity = odd_parity(b);
        f.stop   = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/ps2tx_sense.sv
module ps2tx_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_clk,
    input  logic line_dat,
    output logic clk_s,
    output logic dat_s,
    output logic bus_idle
);
    logic [STAGES-1:0] clk_sr;
    logic [STAGES-1:0] dat_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sr <= '1;
            dat_sr <= '1;
        end else begin
            clk_sr <= {clk_sr[STAGES-2:0], line_clk};
            dat_sr <= {dat_sr[STAGES-2:0], line_dat};
        end
    end

    assign clk_s    = clk_sr[STAGES-1];
    assign dat_s    = dat_sr[STAGES-1];
    assign bus_idle = clk_s && dat_s;

endmodule

// File: rtl/ps2tx_tick.sv
module ps2tx_tick #(
    parameter int HALF_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/ps2tx_fifo.sv
module ps2tx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    // R9: a full queue stays full unless drained or cleared (no overflow)
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clr) |=> full);

    // R10: clear leaves the queue empty
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
    import ps2tx_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BIT_HZ      = 12_500,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    input  logic       fifo_clr,
    input  logic       rx_int,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       ps2_clk_pull,
    output logic       ps2_dat_pull,
    output logic       tx_done
);
    localparam int HALF_CYC = CLK_HZ / (2 * BIT_HZ);
    localparam logic [3:0] LAST_IDX = 4'(FRAME_BITS - 1);

    tx_state_e       state;
    tx_phase_e       phase;
    logic [3:0]      bit_idx;
    logic [FRAME_BITS-1:0] frame_q;
    logic [7:0]      cur_byte;
    logic            retry_pend;
    logic            done_q;

    logic            clk_s;
    logic            dat_s;
    logic            bus_idle;
    logic            tick;
    logic [7:0]      fifo_head;
    logic            fifo_empty;
    logic            fifo_full;
    logic            start;
    logic            fifo_pop;
    logic            abort;
    logic [7:0]      next_byte;

    ps2tx_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst      (rst),
        .line_clk (ps2_clk_i),
        .line_dat (ps2_dat_i),
        .clk_s    (clk_s),
        .dat_s    (dat_s),
        .bus_idle (bus_idle)
    );

    ps2tx_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SEND),
        .tick (tick)
    );

    ps2tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_clr),
        .push      (tx_valid),
        .push_data (tx_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    assign tx_ready  = !fifo_full;
    assign next_byte = retry_pend ? cur_byte : fifo_head;
    assign start     = (state == ST_IDLE) && (retry_pend || !fifo_empty)
                       && !rx_int && bus_idle;
    assign fifo_pop  = start && !retry_pend;
    assign abort     = (state == ST_SEND) && (phase == PH_REL) && tick && !clk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            phase      <= PH_REL;
            bit_idx    <= '0;
            frame_q    <= '1;
            cur_byte   <= '0;
            retry_pend <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_byte   <= next_byte;
                        frame_q    <= build_frame(next_byte);
                        bit_idx    <= '0;
                        phase      <= PH_REL;
                        retry_pend <= 1'b0;
                        state      <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (phase == PH_REL) begin
                            if (!clk_s) begin
                                state      <= ST_IDLE;
                                retry_pend <= 1'b1;
                            end else begin
                                phase <= PH_LOW;
                            end
                        end else begin
                            phase <= PH_REL;
                            if (bit_idx == LAST_IDX) begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                                frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (fifo_clr) retry_pend <= 1'b0;
        end
    end

    assign ps2_clk_pull = (state == ST_SEND) && (phase == PH_LOW);
    assign ps2_dat_pull = (state == ST_SEND) && !frame_q[0];
    assign tx_done      = done_q;

    // R1: a frame begins only from an idle bus with the flag low
    assert_start_on_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && $past(state) == ST_IDLE) |-> ($past(bus_idle) && !$past(rx_int)));

    // R4: DATA holds while CLK is pulled low
    assert_data_hold_low_R4: assert property (@(posedge clk) disable iff (rst)
        (ps2_clk_pull && $past(ps2_clk_pull)) |-> $stable(ps2_dat_pull));

    // R5: both lines released right after an inhibit is seen
    assert_release_on_inhibit_R5: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!ps2_clk_pull && !ps2_dat_pull));

    // R6: a resend carries the abandoned byte
    assert_retry_same_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && $past(state) == ST_IDLE && $past(retry_pend))
        |-> (cur_byte == $past(cur_byte)));

    // R8: completion pulse lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

endmodule

// File: tb/ps2_dev_tx_bench.sv
module ps2_dev_tx_bench;
    localparam int CLK_HZ = 1_000_000;
    localparam int BIT_HZ = 62_500;
    localparam int DEPTH  = 4;
    localparam int HALF   = CLK_HZ / (2 * BIT_HZ);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       fifo_clr = 1'b0;
    logic       rx_int = 1'b0;
    logic       host_clk_low = 1'b0;
    logic       host_dat_low = 1'b0;
    logic       clk_line;
    logic       dat_line;
    logic       clk_pull;
    logic       dat_pull;
    logic       tx_done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign clk_line = !(clk_pull || host_clk_low);
    assign dat_line = !(dat_pull || host_dat_low);

    ps2_dev_tx #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_ps2_dev_tx (
        .clk          (clk),
        .rst          (rst),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .fifo_clr     (fifo_clr),
        .rx_int       (rx_int),
        .ps2_clk_i    (clk_line),
        .ps2_dat_i    (dat_line),
        .ps2_clk_pull (clk_pull),
        .ps2_dat_pull (dat_pull),
        .tx_done      (tx_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [7:0] b);
        return {1'b1, ~^b, b, 1'b0};
    endfunction

    task automatic push_byte(input logic [7:0] b);
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (tx_ready) begin
                tx_valid = 1'b1;
                tx_data  = b;
                @(negedge clk);
                tx_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic expect_frame(input logic [7:0] b, input string req);
        logic [10:0] got;
        int t_prev;
        int t_now;
        bit spacing_ok;
        got = '0;
        t_prev = 0;
        spacing_ok = 1'b1;
        for (int i = 0; i < 11; i++) begin
            @(posedge clk_pull);
            #1;
            got[i] = dat_line;
            t_now = cyc;
            if (i > 0 && (t_now - t_prev) != 2 * HALF) spacing_ok = 1'b0;
            t_prev = t_now;
        end
        check(got == exp_frame(b), req, "frame bits", 32'(got), 32'(exp_frame(b)));
        check((^got[9:1]) == 1'b1, "R3", "odd ones in data+parity", 32'(got[9]), 32'(~^b));
        check(spacing_ok, "R4", "bit period", 32'(spacing_ok), 32'd1);
        @(negedge clk_pull);
        #1;
        check((cyc - t_prev) == HALF, "R4", "low phase length", 32'(cyc - t_prev), 32'(HALF));
        check(tx_done == 1'b1, "R8", "done at release", 32'(tx_done), 32'd1);
        @(posedge clk);
        #1;
        check(tx_done == 1'b0, "R8", "done one cycle", 32'(tx_done), 32'd0);
    endtask

    task automatic quiet_window(input int n, input string req);
        bit seen;
        seen = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
            if (clk_pull || dat_pull || tx_done) seen = 1'b1;
        end
        check(!seen, req, "no bus activity", 32'(seen), 32'd0);
    endtask

    // host pulls CLK low inside the released phase after nbits low pulses
    task automatic inhibit_after(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk_pull);
            @(negedge clk_pull);
        end
        repeat (2) @(posedge clk);
        #1;
        host_clk_low = 1'b1;
        repeat (HALF + 4) @(posedge clk);
        #1;
        check(!clk_pull && !dat_pull, "R5", "lines released after inhibit",
              32'({clk_pull, dat_pull}), 32'd0);
        check(!tx_done, "R8", "no done on abort", 32'(tx_done), 32'd0);
        repeat (30) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] bytes [4];
        logic [7:0] a;
        logic [7:0] b;
        void'($urandom(32'h5A17));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check(tx_ready && !clk_pull && !dat_pull && !tx_done, "R11", "reset outputs",
              32'({tx_ready, clk_pull, dat_pull, tx_done}), 32'b1000);

        // R2, R3 directed parity corners
        push_byte(8'h00); expect_frame(8'h00, "R2");
        push_byte(8'hFF); expect_frame(8'hFF, "R3");
        push_byte(8'h01); expect_frame(8'h01, "R3");
        push_byte(8'hA5); expect_frame(8'hA5, "R2");

        // random bursts, queued behind the flag (R7, R9 ordering)
        for (int r = 0; r < 5; r++) begin
            int n;
            n = 1 + int'($urandom_range(2, 0));
            rx_int = 1'b1;
            for (int k = 0; k < n; k++) begin
                bytes[k] = 8'($urandom());
                push_byte(bytes[k]);
            end
            @(negedge clk);
            rx_int = 1'b0;
            for (int k = 0; k < n; k++) expect_frame(bytes[k], "R9");
        end

        // R1: host holds DATA low (request to send)
        host_dat_low = 1'b1;
        repeat (4) @(posedge clk);
        push_byte(8'h3C);
        quiet_window(40, "R1");
        host_dat_low = 1'b0;
        expect_frame(8'h3C, "R1");

        // R7: flag blocks a new frame
        rx_int = 1'b1;
        push_byte(8'hC3);
        quiet_window(40, "R7");
        rx_int = 1'b0;
        expect_frame(8'hC3, "R7");

        // R9: full queue drops ready, then drains in order
        rx_int = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            bytes[k] = 8'(8'h10 + k * 8'h21);
            push_byte(bytes[k]);
        end
        @(negedge clk);
        check(!tx_ready, "R9", "ready low when full", 32'(tx_ready), 32'd0);
        rx_int = 1'b0;
        for (int k = 0; k < DEPTH; k++) expect_frame(bytes[k], "R9");

        // R5, R6: inhibit mid-frame, resend ahead of queued byte
        a = 8'($urandom());
        b = 8'($urandom());
        rx_int = 1'b1;
        push_byte(a);
        push_byte(b);
        @(negedge clk);
        rx_int = 1'b0;
        inhibit_after(4);
        rx_int = 1'b1;
        host_clk_low = 1'b0;
        quiet_window(40, "R6");
        rx_int = 1'b0;
        expect_frame(a, "R6");
        expect_frame(b, "R6");

        // R5: inhibit during the stop-bit released phase
        push_byte(8'h5E);
        inhibit_after(10);
        host_clk_low = 1'b0;
        expect_frame(8'h5E, "R5");

        // R10: clear drops queued bytes
        rx_int = 1'b1;
        push_byte(8'h11);
        push_byte(8'h22);
        pulse_clr();
        rx_int = 1'b0;
        quiet_window(200, "R10");

        // R10: clear cancels a pending resend
        push_byte(8'h77);
        inhibit_after(3);
        pulse_clr();
        host_clk_low = 1'b0;
        quiet_window(200, "R10");

        // R10: clear in mid-frame completes the frame only
        rx_int = 1'b1;
        push_byte(8'h96);
        push_byte(8'h69);
        @(negedge clk);
        rx_int = 1'b0;
        fork
            expect_frame(8'h96, "R10");
            begin
                repeat (30) @(posedge clk);
                pulse_clr();
            end
        join
        quiet_window(200, "R10");

        // R10: clear wins over a simultaneous push
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = 8'hE7;
        fifo_clr = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        fifo_clr = 1'b0;
        quiet_window(100, "R10");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule